// File: doc/BRIEF.md
# Per-Class Maximum SDU Calculator

This block turns a port's link speed, its configured maximum frame length and eight per-class minimum gate-open windows into eight per-class size limits. A frame larger than its class's limit is meant to be dropped at egress. Without such a limit, a class whose window is too short for a full-size frame, or whose gate never opens, keeps its frames queued forever. The block also reports the port-level maximum length, which includes room for two VLAN tags.

A single start pulse samples all inputs. The block derives the byte time in picoseconds from the speed code. It then computes the time that a maximum frame needs on the wire, including preamble, start delimiter, FCS and inter-frame gap. It walks the eight classes in order, using one shared restoring divider for the classes that need a division. A one-cycle done pulse marks the end. The limit registers hold their values between runs.

Top module: `mtu_sdu_calc`

## Requirements
- R1: After reset, every class limit and the port maximum output are 0 and done is low.
- R2: Speed codes 0, 1, 2 and 3 select 10, 100, 1000 and 2500 Mbit/s. The byte time in picoseconds is 8,000,000 divided by the rate in Mbit/s, giving 800000, 80000, 8000 and 3200.
- R3: The port maximum output equals the configured frame length plus 8.
- R4: A class gets limit 0 if its window is all-ones, or if its window times 1000 is strictly greater than (frame length + 8 + 24) times the byte time. A limit of 0 means no dropping.
- R5: Any other class starts from the quotient of its window times 1000 divided by the byte time, rounded down. This includes a window exactly equal to the needed time.
- R6: A quotient of 0 becomes a limit of 1. A window of 0 therefore gives a limit of 1.
- R7: A quotient above 20 is reduced by 20. A quotient from 1 to 20 is kept as it is.
- R8: Each accepted start produces exactly one done pulse, one cycle wide. All outputs already hold the new values in that cycle.
- R9: A start with speed code 4 to 7 leaves every limit and the port maximum unchanged, and still gives one done pulse.
- R10: A start pulse that arrives during a computation is ignored. The running computation finishes with the inputs it sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sample inputs and begin a computation |
| speed_i | input | 3 | Link speed code |
| frame_len_i | input | 16 | Configured maximum frame length in bytes |
| min_gate_i | input | 256 | Eight 32-bit minimum windows in ns; class c at bits c*32 and up |
| limit_o | output | 136 | Eight 17-bit limits; class c at bits c*17 and up |
| port_max_o | output | 17 | Port maximum length in bytes |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a window that sits exactly on the comparison edge. Its scaled time must equal the needed time, so the division path is taken instead of the bypass. The bench reaches it by deriving windows from the needed time at each speed: an exact match, one nanosecond above it, and windows whose quotient lands on 0, 20 and 21 around the clamp limits. A second start pulse is placed while the divider is busy to show that the sampled inputs are kept.

// File: rtl/mtu_sdu_pkg.sv
// Package: shared constants and types for the per-class SDU calculator.
// Assumes byte times fit in 20 bits (slowest rate 10 Mbit/s).
package mtu_sdu_pkg;
    localparam int PPB_W        = 20;
    localparam int PS_PER_NS    = 1000;
    localparam int TAG_EXTRA    = 8;   // two VLAN tags
    localparam int WIRE_EXTRA   = 24;  // preamble+SFD, FCS, gap
    localparam int L1_TRIM      = 20;  // wire overhead minus FCS

    localparam logic [PPB_W-1:0] PPB_10M   = PPB_W'(800000);
    localparam logic [PPB_W-1:0] PPB_100M  = PPB_W'(80000);
    localparam logic [PPB_W-1:0] PPB_1G    = PPB_W'(8000);
    localparam logic [PPB_W-1:0] PPB_2G5   = PPB_W'(3200);

    typedef enum logic [2:0] {
        RATE_10M  = 3'd0,
        RATE_100M = 3'd1,
        RATE_1G   = 3'd2,
        RATE_2G5  = 3'd3
    } rate_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_CHECK,
        ST_DIV,
        ST_NEXT,
        ST_DONE
    } ctl_state_e;
endpackage

// File: rtl/mtu_speed_decode.sv
// Module: maps a link speed code to picoseconds per byte.
// Assumes: codes above 3 are unrecognised and flagged with valid_o low.
module mtu_speed_decode
    import mtu_sdu_pkg::*;
(
    input  logic [2:0]       speed_i,
    output logic [PPB_W-1:0] ppb_o,
    output logic             valid_o
);
    // Purpose: constant lookup of byte time per rate
    always_comb begin
        valid_o = 1'b1;
        unique case (speed_i)
            RATE_10M:  ppb_o = PPB_10M;
            RATE_100M: ppb_o = PPB_100M;
            RATE_1G:   ppb_o = PPB_1G;
            RATE_2G5:  ppb_o = PPB_2G5;
            default: begin
                ppb_o   = '0;
                valid_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mtu_seq_div.sv
// Module: restoring unsigned divider, one quotient bit per cycle.
// Assumes: divisor nonzero; start_i ignored while busy; result valid for
// one cycle after DVD_W iterations and held until the next start.
module mtu_seq_div #(
    parameter int DVD_W = 37,
    parameter int DVS_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [DVD_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             valid_q;
    logic [DVS_W:0]   shifted;
    logic             fits;

    // Purpose: form the trial remainder for the current bit
    always_comb begin
        shifted = {rem_q, quo_q[DVD_W-1]};
        fits    = (shifted >= {1'b0, dvs_q});
    end

    // Purpose: iterate the shift-subtract loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q   <= '0;
            dvs_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start_i && !busy_q) begin
                dvd_q  <= dividend_i;
                dvs_q  <= divisor_i;
                quo_q  <= dividend_i;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(DVD_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= DVS_W'(shifted - {1'b0, dvs_q});
                    quo_q <= {quo_q[DVD_W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[DVS_W-1:0];
                    quo_q <= {quo_q[DVD_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o  = busy_q;
    assign valid_o = valid_q;
    assign quot_o  = quo_q;

    // R5
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((DVD_W+DVS_W)'(quo_q) * (DVD_W+DVS_W)'(dvs_q)
                     + (DVD_W+DVS_W)'(rem_q)) == (DVD_W+DVS_W)'(dvd_q));
    // R5
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/mtu_class_eval.sv
// Module: decides whether one class needs a limit and clamps its quotient.
// Assumes: need_i is the wire time of a maximum frame in ps; an all-ones
// window means the gate never closes.
module mtu_class_eval
    import mtu_sdu_pkg::*;
#(
    parameter int GATE_W = 32,
    parameter int NEED_W = 37,
    parameter int LIM_W  = 17
) (
    input  logic [GATE_W-1:0] gate_i,
    input  logic [NEED_W-1:0] need_i,
    input  logic [NEED_W-1:0] quot_i,
    output logic              bypass_o,
    output logic [NEED_W-1:0] dividend_o,
    output logic [LIM_W-1:0]  limit_o
);
    localparam int SCALE_W = GATE_W + 10;
    localparam int CMP_W   = (SCALE_W > NEED_W) ? SCALE_W : NEED_W;

    logic [CMP_W-1:0] scaled;
    logic             always_open;
    logic [NEED_W-1:0] adj;

    // Purpose: scale the window to ps and compare with the frame time
    always_comb begin
        scaled      = CMP_W'(gate_i) * CMP_W'(PS_PER_NS);
        always_open = &gate_i;
        bypass_o    = always_open || (scaled > CMP_W'(need_i));
        dividend_o  = scaled[NEED_W-1:0];
    end

    // Purpose: apply the zero floor and layer-1 trim to a quotient
    always_comb begin
        if (quot_i == '0)
            adj = NEED_W'(1);
        else if (quot_i > NEED_W'(L1_TRIM))
            adj = quot_i - NEED_W'(L1_TRIM);
        else
            adj = quot_i;
        limit_o = adj[LIM_W-1:0];
    end
endmodule

// File: rtl/mtu_sdu_calc.sv
// Module: top of the per-class maximum SDU calculator.
// Sequences eight classes through one shared divider and pulses done_o.
// Assumes: start_i is ignored while a run is in progress; outputs are
// registered and change only during a run with a recognised speed.
module mtu_sdu_calc
    import mtu_sdu_pkg::*;
#(
    parameter int NUM_CLASS = 8,
    parameter int GATE_W    = 32,
    parameter int LEN_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [2:0]                    speed_i,
    input  logic [LEN_W-1:0]              frame_len_i,
    input  logic [NUM_CLASS*GATE_W-1:0]   min_gate_i,
    output logic [NUM_CLASS*(LEN_W+1)-1:0] limit_o,
    output logic [LEN_W:0]                port_max_o,
    output logic                          done_o
);
    localparam int FRAME_W = LEN_W + 1;
    localparam int LIM_W   = FRAME_W;
    localparam int NEED_W  = FRAME_W + PPB_W;
    localparam int IDX_W   = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1;

    ctl_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PPB_W-1:0]  ppb_q;
    logic [FRAME_W-1:0] eff_len_q;
    logic [NEED_W-1:0] need_q;
    logic [GATE_W-1:0] gate_q [NUM_CLASS];
    logic [LIM_W-1:0]  lim_q  [NUM_CLASS];
    logic [FRAME_W-1:0] port_max_q;
    logic              done_q;

    logic [PPB_W-1:0]  dec_ppb;
    logic              dec_valid;
    logic [GATE_W-1:0] gate_cur;
    logic              bypass;
    logic [NEED_W-1:0] dividend;
    logic [LIM_W-1:0]  clamped;
    logic              div_start;
    logic              div_busy;
    logic              div_valid;
    logic [NEED_W-1:0] div_quot;

    mtu_speed_decode u_dec (
        .speed_i (speed_i),
        .ppb_o   (dec_ppb),
        .valid_o (dec_valid)
    );

    // Purpose: select the window of the class under evaluation
    always_comb gate_cur = gate_q[idx_q];

    mtu_class_eval #(
        .GATE_W (GATE_W),
        .NEED_W (NEED_W),
        .LIM_W  (LIM_W)
    ) u_eval (
        .gate_i     (gate_cur),
        .need_i     (need_q),
        .quot_i     (div_quot),
        .bypass_o   (bypass),
        .dividend_o (dividend),
        .limit_o    (clamped)
    );

    // Purpose: launch a division for a class that needs a limit
    always_comb div_start = (state_q == ST_CHECK) && !bypass;

    mtu_seq_div #(
        .DVD_W (NEED_W),
        .DVS_W (PPB_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (dividend),
        .divisor_i  (ppb_q),
        .busy_o     (div_busy),
        .valid_o    (div_valid),
        .quot_o     (div_quot)
    );

    // Purpose: control sequence and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            ppb_q      <= '0;
            eff_len_q  <= '0;
            need_q     <= '0;
            port_max_q <= '0;
            done_q     <= 1'b0;
            for (int c = 0; c < NUM_CLASS; c++) begin
                gate_q[c] <= '0;
                lim_q[c]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (dec_valid) begin
                            ppb_q     <= dec_ppb;
                            eff_len_q <= FRAME_W'(frame_len_i) + FRAME_W'(TAG_EXTRA);
                            for (int c = 0; c < NUM_CLASS; c++)
                                gate_q[c] <= min_gate_i[c*GATE_W +: GATE_W];
                            state_q <= ST_PREP;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_PREP: begin
                    need_q  <= (NEED_W'(eff_len_q) + NEED_W'(WIRE_EXTRA)) * NEED_W'(ppb_q);
                    idx_q   <= '0;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (bypass) begin
                        lim_q[idx_q] <= '0;
                        state_q      <= ST_NEXT;
                    end else begin
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        lim_q[idx_q] <= clamped;
                        state_q      <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (idx_q == IDX_W'(NUM_CLASS - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_CHECK;
                    end
                end
                ST_DONE: begin
                    port_max_q <= eff_len_q;
                    done_q     <= 1'b1;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: flatten per-class limits onto the output bus
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_flat
        assign limit_o[g*LIM_W +: LIM_W] = lim_q[g];
    end

    assign port_max_o = port_max_q;
    assign done_o     = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R9
    bad_speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !dec_valid)
        |=> ($stable(limit_o) && $stable(port_max_q) && done_q));
    // R4
    open_gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && (&gate_cur)) |=> (lim_q[idx_q] == '0));
    // R6
    div_limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && div_valid) |=> (lim_q[idx_q] != '0));
    // R3
    port_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (port_max_q == $past(eff_len_q)));
    // R10
    div_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV) |-> (div_busy || div_valid));
endmodule

// File: tb/mtu_sdu_calc_tb_top.sv
module mtu_sdu_calc_tb_top;
    localparam int NC = 8;
    localparam int GW = 32;
    localparam int LW = 16;
    localparam int OW = LW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        speed_i = '0;
    logic [LW-1:0]     frame_len_i = '0;
    logic [NC*GW-1:0]  min_gate_i = '0;
    logic [NC*OW-1:0]  limit_o;
    logic [OW-1:0]     port_max_o;
    logic              done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mtu_sdu_calc dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .speed_i     (speed_i),
        .frame_len_i (frame_len_i),
        .min_gate_i  (min_gate_i),
        .limit_o     (limit_o),
        .port_max_o  (port_max_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned ppb_of(input int code);
        case (code)
            0: return 800000;
            1: return 80000;
            2: return 8000;
            default: return 3200;
        endcase
    endfunction

    // Expected limit from the requirements (R2, R4, R5, R6, R7)
    function automatic longint unsigned exp_lim(input int code, input longint unsigned len,
                                                input longint unsigned g);
        longint unsigned ppb, need, sc, q;
        if (g == 64'hFFFF_FFFF) return 0;
        ppb  = ppb_of(code);
        need = (len + 8 + 24) * ppb;
        sc   = g * 1000;
        if (sc > need) return 0;
        q = sc / ppb;
        if (q == 0) q = 1;
        if (q > 20) q = q - 20;
        return q;
    endfunction

    // Start one run and wait for done; returns 1 if done was seen
    task automatic run(input int code, input int len, input logic [NC*GW-1:0] gates,
                       output bit seen);
        @(negedge clk);
        speed_i = 3'(code);
        frame_len_i = LW'(len);
        min_gate_i = gates;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0;
        for (int k = 0; k < 2000 && !seen; k++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
    endtask

    task automatic check_all(input string tag, input int code, input int len,
                             input logic [NC*GW-1:0] gates);
        for (int c = 0; c < NC; c++)
            chk({tag, " limit"}, longint'(limit_o[c*OW +: OW]),
                exp_lim(code, longint'(len), longint'(gates[c*GW +: GW])));
        chk("R3 port max", longint'(port_max_o), longint'(len + 8));
    endtask

    task automatic t_reset();
        chk("R1 limits", longint'(|limit_o), 0);
        chk("R1 port max", longint'(port_max_o), 0);
        chk("R1 done", longint'(done_o), 0);
    endtask

    // Gigabit: window edges, zero, quotient 20 and 21, open gate
    task automatic t_gig();
        logic [NC*GW-1:0] g;
        bit seen;
        g = {32'd100000, 32'd168, 32'd160, 32'd2000, 32'd12401, 32'd12400, 32'd0, 32'hFFFF_FFFF};
        run(2, 1518, g, seen);
        chk("R8 done seen", longint'(seen), 1);
        check_all("R4 R5 R6 R7 gig", 2, 1518, g);
        chk("R5 boundary", longint'(limit_o[2*OW +: OW]), 1530);
        chk("R7 q21", longint'(limit_o[6*OW +: OW]), 1);
        chk("R7 q20", longint'(limit_o[5*OW +: OW]), 20);
        chk("R6 zero window", longint'(limit_o[1*OW +: OW]), 1);
        @(negedge clk);
        chk("R8 done width", longint'(done_o), 0);
    endtask

    task automatic t_slow();
        logic [NC*GW-1:0] g;
        bit seen;
        g = {32'd400, 32'd17600, 32'd3000000, 32'hFFFF_FFFF, 32'd16000, 32'd799, 32'd500000, 32'd1240000};
        run(0, 1518, g, seen);
        chk("R8 done 10M", longint'(seen), 1);
        check_all("R2 10M", 0, 1518, g);
    endtask

    task automatic t_fast();
        logic [NC*GW-1:0] g;
        bit seen;
        g = {32'd5, 32'd7, 32'd29000, 32'd29018, 32'd29019, 32'd1000, 32'd40, 32'd64};
        run(3, 9000, g, seen);
        chk("R8 done 2G5", longint'(seen), 1);
        check_all("R2 2G5", 3, 9000, g);
    endtask

    task automatic t_hundred();
        logic [NC*GW-1:0] g;
        bit seen;
        g = {32'd7680, 32'd7681, 32'd1, 32'd33, 32'd100, 32'd3000, 32'hFFFF_FFFE, 32'd80};
        run(1, 64, g, seen);
        chk("R8 done 100M", longint'(seen), 1);
        check_all("R2 100M", 1, 64, g);
    endtask

    // R9: unrecognised speed keeps previous results
    task automatic t_bad_speed();
        logic [NC*OW-1:0] prev_l;
        logic [OW-1:0] prev_p;
        bit seen;
        prev_l = limit_o;
        prev_p = port_max_o;
        run(6, 300, '1, seen);
        chk("R9 done", longint'(seen), 1);
        chk("R9 limits held", longint'(limit_o != prev_l), 0);
        chk("R9 port max held", longint'(port_max_o), longint'(prev_p));
        repeat (3) @(negedge clk);
        chk("R9 limits still held", longint'(limit_o != prev_l), 0);
    endtask

    // R10: second start while busy is ignored
    task automatic t_busy_start();
        logic [NC*GW-1:0] g;
        bit seen;
        g = {32'd300, 32'd200, 32'd100, 32'd5000, 32'd4000, 32'd3000, 32'd2000, 32'd1000};
        @(negedge clk);
        speed_i = 3'd2; frame_len_i = 16'd1000; min_gate_i = g; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        speed_i = 3'd0; frame_len_i = 16'd64; min_gate_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0;
        for (int k = 0; k < 2000 && !seen; k++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        chk("R10 done", longint'(seen), 1);
        check_all("R10 first inputs kept", 2, 1000, g);
        repeat (5) @(negedge clk);
        chk("R10 no second done", longint'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gig();
        t_slow();
        t_fast();
        t_hundred();
        t_bad_speed();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule